// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block supervises software by counting down a 24-bit value at a quarter of the input clock rate. Software reloads the count by writing a two-word key to the feed address, and it must do so before the count runs out. A feed is honoured only when the count has already dropped to a programmable window level, so a feed that comes too early is treated as an error, as are a broken key pair and the count running out. Once enabled, the watchdog stays enabled until a reset or until it has reported a fault.

A fault is answered in one of two ways, chosen by a mode bit. In interrupt mode the block raises a timeout flag on its interrupt line. In reset mode it pulses a reset request for one cycle and sets a sticky flag. Only the power-on reset or a software write clears that flag, so after a system reset software can tell that the watchdog caused it. A 10-bit warning level lets the block raise an early interrupt a chosen number of ticks before the count runs out.

All access goes through a single write/read port. There is a write strobe, a 3-bit address and 32-bit write data. Read data is a combinational function of the address.

Top module: `win_watchdog`

## Requirements
- R1: After reset, the control word (address 0) reads 0, the count (address 3) reads 0xFF, the window (address 5) reads 0xFFFFFF, and irq and rst_req are low.
- R2: In the control word, bit 0 (enable) and bit 1 (reset mode) are set by writing 1. Writing 0 to either bit has no effect. Enable is cleared only by rst_n or by a watchdog fault.
- R3: While the watchdog is enabled, the count decreases by one every 4 clocks. After a valid feed, the first decrement lands exactly 4 clock edges after the edge that took the feed.
- R4: A valid feed is a write of 0xAA to the feed address (2) followed by a write of 0x55 to the same address, with no other write in between. A valid feed loads the count from the reload register (address 1).
- R5: Writing the reload register does not change the count until the next valid feed.
- R6: While enabled, a valid feed taken when the count is above the window register is a fault and does not reload the count. A feed taken when the count equals the window is accepted.
- R7: While enabled, the following are faults: after 0xAA, a feed-address write of any value other than 0x55 or 0xAA; after 0xAA, a write to any other address; and a 0x55 feed write that is not preceded by 0xAA. While disabled, none of these raises a fault.
- R8: On a tick with the count at 0, the watchdog expires and raises a fault. This happens 4*(reload+1) clocks after the feed.
- R9: In interrupt mode (bit 1 = 0), a fault sets timeout flag bit 3, drives irq high, clears enable, and stops the count.
- R10: In reset mode, a fault pulses rst_req high for exactly one cycle and sets sticky flag bit 4. The flag survives rst_n and is cleared by por_n or by writing 1 to bit 4.
- R11: When a tick brings the count to the 10-bit warning value (address 4), warning flag bit 2 is set and irq goes high. Writing 1 to bit 2 clears the flag and has no effect on enable.
- R12: Reading address 3 returns the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system reset; clears everything except the sticky flag |
| por_n | input | 1 | Active-low power-on reset; clears the sticky watchdog-reset flag |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq | output | 1 | Warning or timeout interrupt |
| rst_req | output | 1 | One-cycle reset request on a fault in reset mode |

## Verification
A register write, and any fault it causes (sequence break, early feed), shows in the read data, irq and rst_req right after the clock edge that takes the write. The count updates in the cycle after the feed edge. Decrements, the warning and expiry fall on edges 4, 8, 12 and so on after the feed edge. The bench drives every write between falling edges. It then counts whole clock edges from the feed edge and samples one nanosecond after a falling edge, one edge before and one edge after each expected change, so an off-by-one in the prescaler or the compare shows as a mismatch.

// File: rtl/wwd_pkg.sv
package wwd_pkg;

    localparam int ADDR_W = 3;

    // register map
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_RELOAD = 3'd1;
    localparam logic [ADDR_W-1:0] A_FEED   = 3'd2;
    localparam logic [ADDR_W-1:0] A_COUNT  = 3'd3;
    localparam logic [ADDR_W-1:0] A_WARN   = 3'd4;
    localparam logic [ADDR_W-1:0] A_WINDOW = 3'd5;

    // control word bit positions
    localparam int B_EN    = 0;
    localparam int B_RMODE = 1;
    localparam int B_WARN  = 2;
    localparam int B_TOUT  = 3;
    localparam int B_WDRST = 4;

    // feed key pair
    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_e;

endpackage

// File: rtl/wwd_prescaler.sv
module wwd_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);

    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] phase;
    } pre_t;

    pre_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = 1'b0;
        if (!run || restart) begin
            s_d.phase = '0;
        end else if (s_q.phase == LAST) begin
            s_d.phase = '0;
            tick      = 1'b1;
        end else begin
            s_d.phase = s_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    generate
        if (DIV > 1) begin : g_gap
            // R3: ticks never fall on adjacent cycles
            p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick)
                else $error("tick on adjacent cycles");
        end
    endgenerate

endmodule

// File: rtl/wwd_feed_check.sv
module wwd_feed_check #(
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [wwd_pkg::ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    output logic                       feed_pair,
    output logic                       seq_bad
);
    import wwd_pkg::*;

    localparam logic [DATA_W-1:0] K1 = DATA_W'(KEY_FIRST);
    localparam logic [DATA_W-1:0] K2 = DATA_W'(KEY_SECOND);

    typedef struct packed {
        seq_e st;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        feed_pair = 1'b0;
        seq_bad   = 1'b0;
        if (wr_en) begin
            if (wr_addr == A_FEED) begin
                if (wr_data == K1) begin
                    s_d.st = SEQ_ARMED;
                end else begin
                    s_d.st = SEQ_IDLE;
                    if (s_q.st == SEQ_ARMED && wr_data == K2) feed_pair = 1'b1;
                    else                                      seq_bad   = 1'b1;
                end
            end else if (s_q.st == SEQ_ARMED) begin
                s_d.st  = SEQ_IDLE;
                seq_bad = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SEQ_IDLE};
        else        s_q <= s_d;
    end

    // R4: a completed pair leaves the sequencer idle
    p_pair_rearms_r4: assert property (@(posedge clk) disable iff (!rst_n)
        feed_pair |=> s_q.st == SEQ_IDLE)
        else $error("sequencer still armed after a pair");

    // R7: an error and a good pair never coincide
    p_one_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(feed_pair && seq_bad))
        else $error("pair and error at once");

endmodule

// File: rtl/wwd_counter.sv
module wwd_counter #(
    parameter int CNT_W  = 24,
    parameter int WARN_W = 10,
    parameter logic [CNT_W-1:0] INIT = 'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_val,
    input  logic [WARN_W-1:0] warn_val,
    output logic [CNT_W-1:0]  count,
    output logic              warn_hit,
    output logic              expire
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t s_d, s_q;
    logic [CNT_W-1:0] dec;

    always_comb begin
        s_d      = s_q;
        dec      = s_q.cnt - 1'b1;
        warn_hit = 1'b0;
        expire   = 1'b0;
        if (load) begin
            s_d.cnt = load_val;
        end else if (tick) begin
            if (s_q.cnt == '0) begin
                expire = 1'b1;
            end else begin
                s_d.cnt  = dec;
                warn_hit = (dec == CNT_W'(warn_val));
            end
        end
    end

    assign count = s_q.cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{cnt: INIT};
        else        s_q <= s_d;
    end

    // R5: without a load the count never rises
    p_count_no_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> count <= $past(count))
        else $error("count rose without a load");

    // R4: a load puts the reload value in the count
    p_load_takes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == $past(load_val))
        else $error("load value not taken");

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog #(
    parameter int CNT_W    = 24,
    parameter int WARN_W   = 10,
    parameter int PRESCALE = 4,
    parameter int DATA_W   = 32,
    parameter logic [CNT_W-1:0] COUNT_INIT = 'hFF
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       por_n,
    input  logic                       bus_we,
    input  logic [wwd_pkg::ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic                       irq,
    output logic                       rst_req
);
    import wwd_pkg::*;

    typedef struct packed {
        logic              en;
        logic              rmode;
        logic              warn_f;
        logic              tout_f;
        logic              rst_req;
        logic [CNT_W-1:0]  reload;
        logic [CNT_W-1:0]  window;
        logic [WARN_W-1:0] warn;
    } regs_t;

    localparam regs_t REGS_INIT = '{
        en: 1'b0, rmode: 1'b0, warn_f: 1'b0, tout_f: 1'b0, rst_req: 1'b0,
        reload: COUNT_INIT, window: '1, warn: '0};

    regs_t r_d, r_q;
    logic  wdrst_d, wdrst_q;

    logic             tick, feed_pair, seq_bad, warn_hit, expire;
    logic             early, fault, load, ctrl_wr;
    logic [CNT_W-1:0] count;

    wwd_prescaler #(.DIV(PRESCALE)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(r_q.en), .restart(load), .tick(tick));

    wwd_feed_check #(.DATA_W(DATA_W)) u_feed (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .wr_addr(bus_addr),
        .wr_data(bus_wdata), .feed_pair(feed_pair), .seq_bad(seq_bad));

    wwd_counter #(.CNT_W(CNT_W), .WARN_W(WARN_W), .INIT(COUNT_INIT)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
        .load_val(r_q.reload), .warn_val(r_q.warn), .count(count),
        .warn_hit(warn_hit), .expire(expire));

    always_comb begin
        ctrl_wr = bus_we && (bus_addr == A_CTRL);
        early   = count > r_q.window;
        fault   = r_q.en && (seq_bad || (feed_pair && early) || expire);
        load    = feed_pair && !(r_q.en && early);
    end

    always_comb begin
        r_d         = r_q;
        r_d.rst_req = 1'b0;
        if (bus_we) begin
            case (bus_addr)
                A_CTRL: begin
                    if (bus_wdata[B_EN])    r_d.en     = 1'b1;
                    if (bus_wdata[B_RMODE]) r_d.rmode  = 1'b1;
                    if (bus_wdata[B_WARN])  r_d.warn_f = 1'b0;
                    if (bus_wdata[B_TOUT])  r_d.tout_f = 1'b0;
                end
                A_RELOAD: r_d.reload = bus_wdata[CNT_W-1:0];
                A_WARN:   r_d.warn   = bus_wdata[WARN_W-1:0];
                A_WINDOW: r_d.window = bus_wdata[CNT_W-1:0];
                default: ;
            endcase
        end
        if (warn_hit) r_d.warn_f = 1'b1;
        if (fault) begin
            r_d.en = 1'b0;
            if (r_q.rmode) r_d.rst_req = 1'b1;
            else           r_d.tout_f  = 1'b1;
        end
    end

    always_comb begin
        wdrst_d = wdrst_q;
        if (ctrl_wr && bus_wdata[B_WDRST]) wdrst_d = 1'b0;
        if (fault && r_q.rmode)            wdrst_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= REGS_INIT;
        else        r_q <= r_d;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) wdrst_q <= 1'b0;
        else        wdrst_q <= wdrst_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL: begin
                bus_rdata[B_EN]    = r_q.en;
                bus_rdata[B_RMODE] = r_q.rmode;
                bus_rdata[B_WARN]  = r_q.warn_f;
                bus_rdata[B_TOUT]  = r_q.tout_f;
                bus_rdata[B_WDRST] = wdrst_q;
            end
            A_RELOAD: bus_rdata = DATA_W'(r_q.reload);
            A_COUNT:  bus_rdata = DATA_W'(count);
            A_WARN:   bus_rdata = DATA_W'(r_q.warn);
            A_WINDOW: bus_rdata = DATA_W'(r_q.window);
            default:  bus_rdata = '0;
        endcase
    end

    assign irq     = r_q.warn_f | r_q.tout_f;
    assign rst_req = r_q.rst_req;

    // R2: a control write with enable low cannot stop a running watchdog
    p_enable_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.en && ctrl_wr && !bus_wdata[B_EN] && !fault) |=> r_q.en)
        else $error("enable dropped by software");

    // R9: any fault leaves the watchdog disabled
    p_fault_stops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !r_q.en)
        else $error("still enabled after fault");

    // R6: an early feed never raises the count
    p_early_no_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.en && feed_pair && early) |=> count <= $past(count))
        else $error("early feed reloaded the count");

    // R10: reset request lasts a single cycle
    p_rst_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req)
        else $error("reset request longer than one cycle");

    // R10: sticky flag holds unless software clears it
    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!por_n)
        (wdrst_q && !(ctrl_wr && bus_wdata[B_WDRST])) |=> wdrst_q)
        else $error("sticky flag lost");

endmodule

// File: tb/win_watchdog_bench.sv
`timescale 1ns/1ps
module win_watchdog_bench;

    localparam logic [2:0] A_CTRL = 3'd0, A_RELOAD = 3'd1, A_FEED = 3'd2,
                           A_COUNT = 3'd3, A_WARN = 3'd4, A_WINDOW = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, rst_req;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    win_watchdog u_win_watchdog (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .rst_req(rst_req));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic do_reset(input bit full);
        @(negedge clk);
        rst_n = 1'b0;
        if (full) por_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        por_n = 1'b1;
    endtask

    // write lands on the posedge after the next falling edge; returns just after it
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic feed();
        wr(A_FEED, 32'hAA);
        wr(A_FEED, 32'h55);
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        do_reset(1);
        rd(A_CTRL, v);   chk("R1 ctrl", v, 0);
        rd(A_COUNT, v);  chk("R1 R12 count", v, 32'hFF);
        rd(A_WINDOW, v); chk("R1 window", v, 32'hFFFFFF);
        chk("R1 irq", irq, 0);
        chk("R1 rst_req", rst_req, 0);
    endtask

    task automatic t_enable_lock();
        logic [31:0] v;
        do_reset(1);
        wr(A_CTRL, 32'h3);
        rd(A_CTRL, v); chk("R2 set", v & 3, 3);
        wr(A_CTRL, 32'h0);
        rd(A_CTRL, v); chk("R2 write zero ignored", v & 3, 3);
        do_reset(0);
        rd(A_CTRL, v); chk("R2 cleared by reset", v & 3, 0);
    endtask

    task automatic t_reload_defer();
        logic [31:0] v;
        do_reset(1);
        wr(A_RELOAD, 5);
        feed();
        rd(A_COUNT, v); chk("R4 feed loads", v, 5);
        wr(A_RELOAD, 9);
        rd(A_COUNT, v); chk("R5 reload deferred", v, 5);
        feed();
        rd(A_COUNT, v); chk("R4 second feed loads", v, 9);
    endtask

    task automatic t_expire_irq();
        logic [31:0] v;
        do_reset(1);
        wr(A_RELOAD, 5);
        wr(A_CTRL, 1);
        feed();                                   // feed edge = E0
        rd(A_COUNT, v); chk("R4 count after feed", v, 5);
        repeat (3) @(negedge clk);                // E3
        rd(A_COUNT, v); chk("R3 no step before 4", v, 5);
        @(negedge clk);                           // E4
        rd(A_COUNT, v); chk("R3 step at 4", v, 4);
        repeat (19) @(negedge clk);               // E23
        rd(A_CTRL, v); chk("R8 not yet expired", (v >> 3) & 1, 0);
        @(negedge clk);                           // E24
        rd(A_CTRL, v);
        chk("R8 expired timeout flag", (v >> 3) & 1, 1);
        chk("R9 enable cleared", v & 1, 0);
        chk("R9 irq", irq, 1);
        chk("R9 no reset request", rst_req, 0);
        repeat (8) @(negedge clk);
        rd(A_COUNT, v); chk("R9 count stopped", v, 0);
    endtask

    task automatic t_warning();
        logic [31:0] v;
        do_reset(1);
        wr(A_RELOAD, 6);
        wr(A_WARN, 3);
        wr(A_CTRL, 1);
        feed();                                   // E0
        repeat (11) @(negedge clk);               // E11
        rd(A_CTRL, v); chk("R11 warn before", (v >> 2) & 1, 0);
        chk("R11 irq before", irq, 0);
        @(negedge clk);                           // E12: count 3
        rd(A_CTRL, v); chk("R11 warn set", (v >> 2) & 1, 1);
        chk("R11 irq on warn", irq, 1);
        wr(A_CTRL, 32'h4);
        rd(A_CTRL, v);
        chk("R11 warn cleared", (v >> 2) & 1, 0);
        chk("R11 R2 enable kept", v & 1, 1);
        chk("R11 irq cleared", irq, 0);
    endtask

    task automatic t_window();
        logic [31:0] v;
        // early feed rejected
        do_reset(1);
        wr(A_RELOAD, 20);
        feed();
        wr(A_RELOAD, 30);
        wr(A_WINDOW, 10);
        wr(A_CTRL, 1);                            // Ee
        feed();                                   // 0x55 at Ee+4, tick there too
        rd(A_COUNT, v); chk("R6 early feed no reload", v, 19);
        rd(A_CTRL, v);
        chk("R6 early feed fault", (v >> 3) & 1, 1);
        chk("R6 early feed disables", v & 1, 0);
        // feed at count equal to window accepted
        do_reset(1);
        wr(A_RELOAD, 12);
        feed();
        wr(A_WINDOW, 10);
        wr(A_CTRL, 1);                            // Ee
        repeat (8) @(negedge clk);                // Ee+8, count 10
        feed();                                   // 0x55 at Ee+12
        rd(A_COUNT, v); chk("R6 in-window feed reloads", v, 12);
        rd(A_CTRL, v); chk("R6 in-window no fault", v & 32'h9, 1);
    endtask

    task automatic t_sequence_errors();
        logic [31:0] v;
        do_reset(1);
        wr(A_CTRL, 1);
        wr(A_FEED, 32'hAA);
        wr(A_FEED, 32'h12);
        rd(A_CTRL, v); chk("R7 wrong second key", v & 32'h9, 32'h8);
        do_reset(1);
        wr(A_CTRL, 1);
        wr(A_FEED, 32'hAA);
        wr(A_WARN, 1);
        rd(A_CTRL, v); chk("R7 other write between", v & 32'h9, 32'h8);
        do_reset(1);
        wr(A_CTRL, 1);
        wr(A_FEED, 32'h55);
        rd(A_CTRL, v); chk("R7 lone second key", v & 32'h9, 32'h8);
        do_reset(1);
        wr(A_FEED, 32'h55);
        rd(A_CTRL, v); chk("R7 disabled no fault", v, 0);
        chk("R7 disabled irq", irq, 0);
    endtask

    task automatic t_reset_mode();
        logic [31:0] v;
        do_reset(1);
        wr(A_RELOAD, 50);
        wr(A_CTRL, 3);
        wr(A_FEED, 32'hAA);
        wr(A_FEED, 32'h0);
        chk("R10 reset request", rst_req, 1);
        rd(A_CTRL, v); chk("R10 sticky flag, no timeout flag", v & 32'h19, 32'h10);
        chk("R10 no irq", irq, 0);
        @(negedge clk);
        chk("R10 request one cycle", rst_req, 0);
        do_reset(0);
        rd(A_CTRL, v); chk("R10 flag survives rst_n", v, 32'h10);
        wr(A_CTRL, 32'h10);
        rd(A_CTRL, v); chk("R10 flag cleared by write", v, 0);
        wr(A_CTRL, 3);
        wr(A_FEED, 32'h55);
        rd(A_CTRL, v); chk("R10 flag set again", (v >> 4) & 1, 1);
        do_reset(1);
        rd(A_CTRL, v); chk("R10 flag cleared by por", v, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        t_reset_state();
        t_enable_lock();
        t_reload_defer();
        t_expire_irq();
        t_warning();
        t_window();
        t_sequence_errors();
        t_reset_mode();
        finish_run();
    end

endmodule